// File: doc/BRIEF.md
# Aggregated Bit Vector Matcher

This block is the final stage of a multi-field rule classifier built on per-interval bit vectors. For every dimension it holds one full rule vector per interval (bit k stands for rule k, and bit 0 has the highest priority). When a vector is written, the block also stores a short summary beside it. Each summary bit covers one group of `AGG_SIZE` adjacent rule bits and is set when any bit of that group is set.

A lookup supplies one interval index per dimension. The index search itself is done upstream. The block first ANDs the summaries of all dimensions to find candidate groups. It then visits the candidates from the lowest group upward, one per cycle. At each visit it fetches that group's bits from every dimension and ANDs them. The scan ends at the first group whose AND is non-zero, and the lowest set bit of that group names the winning rule. A candidate whose AND turns out empty is a false match. A false match costs one cycle and sets a flag. The number of group fetches is reported with the result.

Control is a four-state machine. IDLE waits for a start and moves to AGG. AGG always moves to SCAN after latching the candidate set. SCAN stays in SCAN after an empty group while candidates remain. SCAN moves to DONE on a hit, when the last candidate is exhausted, or when no candidate exists. DONE always returns to IDLE.

Top module: `aggvec_match`

## Requirements
- R1: While reset is held and right after it, busy, done, hit, false_match, rule_idx and fetch_cnt are all 0.
- R2: A configuration write to (dimension, interval) replaces that full vector, and its summary bit g becomes the OR of full-vector bits g*AGG_SIZE to g*AGG_SIZE+AGG_SIZE-1. Candidate groups are the groups whose summary bit is 1 in every dimension.
- R3: hit is 1 exactly when the AND of the addressed full vectors over all dimensions is non-zero. rule_idx is then the lowest set bit position of that AND.
- R4: fetch_cnt counts the candidate groups visited in ascending order. On a hit it is the number of candidates at or below the winning group; on a miss it is the number of all candidates. It never exceeds N_RULES/AGG_SIZE.
- R5: false_match is 1 exactly when at least one visited candidate group had an all-zero AND.
- R6: With start sampled at clock edge 0, done is high for exactly one cycle following edge 1+max(fetch_cnt,1). busy is high from edge 0 until that edge and is never high together with done.
- R7: start is accepted only while busy and done are both 0. A start at any other time does not change the running lookup or its result.
- R8: A configuration write while busy or done is high is dropped and leaves all stored vectors unchanged.
- R9: When a configuration write and an accepted start fall in the same cycle, the write takes effect first, and the lookup sees the new vector.
- R10: The result outputs (hit, rule_idx, false_match, fetch_cnt) hold their values from done until the next accepted start.
- R11: On a miss, rule_idx is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dim | input | 1 | Dimension selected for the write |
| cfg_intv | input | 3 | Interval selected for the write |
| cfg_vec | input | 32 | Full rule vector to store |
| start | input | 1 | Lookup request |
| lk_intv | input | 6 | Interval index per dimension, dimension 0 in the low bits |
| busy | output | 1 | Lookup in progress (states AGG and SCAN) |
| done | output | 1 | One-cycle completion pulse (state DONE) |
| hit | output | 1 | A rule matched in every dimension |
| rule_idx | output | 5 | Highest-priority matching rule |
| false_match | output | 1 | A candidate group proved empty |
| fetch_cnt | output | 4 | Group fetches made by the last lookup |

## Verification
Two functions can land in the same cycle: a configuration write and the acceptance of a lookup start. The bench provokes this by raising both strobes together on a vector that turns a miss into a hit. It judges the result by whether the lookup reports the newly written rule. The bench also injects a write and a second start during a running scan. The first lookup must report the old data unchanged, with unchanged latency, and a later plain lookup must confirm that the stored vector was not altered.

// File: rtl/aggvec_pkg.sv
package aggvec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_AGG  = 2'd1,
        ST_SCAN = 2'd2,
        ST_DONE = 2'd3
    } scan_state_t;

endpackage

// File: rtl/aggvec_first_set.sv
module aggvec_first_set #(
    parameter int W = 8,
    localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // lowest set position wins
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/aggvec_store.sv
module aggvec_store #(
    parameter int N_RULES  = 32,
    parameter int AGG_SIZE = 4,
    parameter int N_INTV   = 8,
    localparam int N_GRP   = N_RULES / AGG_SIZE,
    localparam int INTV_W  = (N_INTV > 1) ? $clog2(N_INTV) : 1,
    localparam int GRP_W   = (N_GRP > 1) ? $clog2(N_GRP) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [INTV_W-1:0]   wr_intv,
    input  logic [N_RULES-1:0]  wr_vec,
    input  logic [INTV_W-1:0]   agg_intv,
    output logic [N_GRP-1:0]    agg_vec,
    input  logic [INTV_W-1:0]   grp_intv,
    input  logic [GRP_W-1:0]    grp_sel,
    output logic [AGG_SIZE-1:0] grp_bits
);

    logic [N_RULES-1:0] full_mem [N_INTV];
    logic [N_GRP-1:0]   sum_mem  [N_INTV];
    logic [N_GRP-1:0]   wr_sum;

    // summary bits computed from the incoming vector at write time
    for (genvar g = 0; g < N_GRP; g++) begin : g_sum
        assign wr_sum[g] = |wr_vec[g*AGG_SIZE +: AGG_SIZE];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_INTV; i++) begin
                full_mem[i] <= '0;
                sum_mem[i]  <= '0;
            end
        end else if (wr_en) begin
            full_mem[wr_intv] <= wr_vec;
            sum_mem[wr_intv]  <= wr_sum;
        end
    end

    assign agg_vec  = sum_mem[agg_intv];
    assign grp_bits = full_mem[grp_intv][grp_sel*AGG_SIZE +: AGG_SIZE];

endmodule

// File: rtl/aggvec_match.sv
module aggvec_match
    import aggvec_pkg::*;
#(
    parameter int N_RULES  = 32,
    parameter int AGG_SIZE = 4,
    parameter int N_DIMS   = 2,
    parameter int N_INTV   = 8,
    localparam int N_GRP   = N_RULES / AGG_SIZE,
    localparam int GRP_W   = (N_GRP > 1) ? $clog2(N_GRP) : 1,
    localparam int BIT_W   = (AGG_SIZE > 1) ? $clog2(AGG_SIZE) : 1,
    localparam int RULE_W  = $clog2(N_RULES),
    localparam int INTV_W  = (N_INTV > 1) ? $clog2(N_INTV) : 1,
    localparam int DIM_W   = (N_DIMS > 1) ? $clog2(N_DIMS) : 1,
    localparam int CNT_W   = $clog2(N_GRP + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [DIM_W-1:0]           cfg_dim,
    input  logic [INTV_W-1:0]          cfg_intv,
    input  logic [N_RULES-1:0]         cfg_vec,
    input  logic                       start,
    input  logic [N_DIMS*INTV_W-1:0]   lk_intv,
    output logic                       busy,
    output logic                       done,
    output logic                       hit,
    output logic [RULE_W-1:0]          rule_idx,
    output logic                       false_match,
    output logic [CNT_W-1:0]           fetch_cnt
);

    scan_state_t state_q, state_d;

    logic [INTV_W-1:0]   intv_q [N_DIMS];
    logic [N_GRP-1:0]    cand_q;
    logic                hit_q;
    logic [RULE_W-1:0]   rule_q;
    logic                fm_q;
    logic [CNT_W-1:0]    cnt_q;

    logic [N_GRP-1:0]    sum_rd [N_DIMS];
    logic [AGG_SIZE-1:0] grp_rd [N_DIMS];
    logic [N_GRP-1:0]    sum_and;
    logic [AGG_SIZE-1:0] grp_and;

    logic                grp_found;
    logic [GRP_W-1:0]    grp_idx;
    logic                bit_found;
    logic [BIT_W-1:0]    bit_idx;
    logic [N_GRP-1:0]    grp_onehot;
    logic [N_GRP-1:0]    cand_rest;

    logic cfg_ok;
    logic start_ok;

    assign cfg_ok   = cfg_we && (state_q == ST_IDLE);
    assign start_ok = start  && (state_q == ST_IDLE);

    // per-dimension vector memories
    for (genvar d = 0; d < N_DIMS; d++) begin : g_dim
        aggvec_store #(
            .N_RULES  (N_RULES),
            .AGG_SIZE (AGG_SIZE),
            .N_INTV   (N_INTV)
        ) u_store (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (cfg_ok && (cfg_dim == DIM_W'(d))),
            .wr_intv  (cfg_intv),
            .wr_vec   (cfg_vec),
            .agg_intv (intv_q[d]),
            .agg_vec  (sum_rd[d]),
            .grp_intv (intv_q[d]),
            .grp_sel  (grp_idx),
            .grp_bits (grp_rd[d])
        );
    end

    // cross-dimension conjunction of summaries and of the fetched group
    always_comb begin
        sum_and = '1;
        grp_and = '1;
        for (int d = 0; d < N_DIMS; d++) begin
            sum_and = sum_and & sum_rd[d];
            grp_and = grp_and & grp_rd[d];
        end
    end

    aggvec_first_set #(.W(N_GRP)) u_pick_grp (
        .vec   (cand_q),
        .found (grp_found),
        .idx   (grp_idx)
    );

    aggvec_first_set #(.W(AGG_SIZE)) u_pick_bit (
        .vec   (grp_and),
        .found (bit_found),
        .idx   (bit_idx)
    );

    assign grp_onehot = N_GRP'(1) << grp_idx;
    assign cand_rest  = cand_q & ~grp_onehot;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_ok) state_d = ST_AGG;
            ST_AGG:  state_d = ST_SCAN;
            ST_SCAN: begin
                if (!grp_found)          state_d = ST_DONE;
                else if (bit_found)      state_d = ST_DONE;
                else if (cand_rest == '0) state_d = ST_DONE;
                else                     state_d = ST_SCAN;
            end
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    // datapath and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int d = 0; d < N_DIMS; d++) intv_q[d] <= '0;
            cand_q <= '0;
            hit_q  <= 1'b0;
            rule_q <= '0;
            fm_q   <= 1'b0;
            cnt_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_ok) begin
                        for (int d = 0; d < N_DIMS; d++)
                            intv_q[d] <= lk_intv[d*INTV_W +: INTV_W];
                        cand_q <= '0;
                        hit_q  <= 1'b0;
                        rule_q <= '0;
                        fm_q   <= 1'b0;
                        cnt_q  <= '0;
                    end
                end
                ST_AGG: cand_q <= sum_and;
                ST_SCAN: begin
                    if (grp_found) begin
                        cnt_q <= cnt_q + CNT_W'(1);
                        if (bit_found) begin
                            hit_q  <= 1'b1;
                            rule_q <= RULE_W'(grp_idx) * RULE_W'(AGG_SIZE) + RULE_W'(bit_idx);
                        end else begin
                            fm_q   <= 1'b1;
                            cand_q <= cand_rest;
                        end
                    end
                end
                ST_DONE: ;
            endcase
        end
    end

    assign busy        = (state_q == ST_AGG) || (state_q == ST_SCAN);
    assign done        = (state_q == ST_DONE);
    assign hit         = hit_q;
    assign rule_idx    = rule_q;
    assign false_match = fm_q;
    assign fetch_cnt   = cnt_q;

endmodule

// File: rtl/aggvec_match_chk.sv
module aggvec_match_chk #(
    parameter int N_GRP  = 8,
    parameter int RULE_W = 5,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              hit,
    input logic [RULE_W-1:0] rule_idx,
    input logic              false_match,
    input logic [CNT_W-1:0]  fetch_cnt
);

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_done_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    assert_busy_needs_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done) |=> (busy || ($stable(hit) && $stable(rule_idx)
                                       && $stable(false_match) && $stable(fetch_cnt))));

    assert_hit_fetched_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && hit) |-> (fetch_cnt != '0));

    assert_fetch_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_cnt <= CNT_W'(N_GRP));

    assert_miss_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !hit) |-> (false_match == (fetch_cnt != '0)));

    assert_hit_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && hit && false_match) |-> (fetch_cnt >= CNT_W'(2)));

    assert_miss_rule_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !hit) |-> (rule_idx == '0));

endmodule

bind aggvec_match aggvec_match_chk #(
    .N_GRP  (N_GRP),
    .RULE_W (RULE_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .hit         (hit),
    .rule_idx    (rule_idx),
    .false_match (false_match),
    .fetch_cnt   (fetch_cnt)
);

// File: tb/aggvec_match_test.sv
`timescale 1ns/1ps
module aggvec_match_test;

    localparam int N  = 32;
    localparam int A  = 4;
    localparam int G  = N / A;
    localparam int NI = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic        cfg_dim;
    logic [2:0]  cfg_intv;
    logic [31:0] cfg_vec;
    logic        start;
    logic [5:0]  lk_intv;
    logic        busy, done, hit, false_match;
    logic [4:0]  rule_idx;
    logic [3:0]  fetch_cnt;

    int tests = 0;
    int fails = 0;
    logic [31:0] ref_mem [2][NI];

    always #2.5 clk = ~clk;

    aggvec_match uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dim(cfg_dim),
        .cfg_intv(cfg_intv), .cfg_vec(cfg_vec), .start(start), .lk_intv(lk_intv),
        .busy(busy), .done(done), .hit(hit), .rule_idx(rule_idx),
        .false_match(false_match), .fetch_cnt(fetch_cnt)
    );

    task automatic check(input string req, input string what, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic ref_eval(input int i0, input int i1,
                            output int eh, output int er, output int efm, output int ef);
        logic [31:0] a0, a1, full;
        a0 = ref_mem[0][i0];
        a1 = ref_mem[1][i1];
        full = a0 & a1;
        eh = 0; er = 0; efm = 0; ef = 0;
        for (int g = 0; g < G; g++) begin
            if ((|a0[g*A +: A]) && (|a1[g*A +: A])) begin
                ef++;
                if (|full[g*A +: A]) begin
                    eh = 1;
                    for (int b = A - 1; b >= 0; b--) if (full[g*A + b]) er = g*A + b;
                    break;
                end else begin
                    efm = 1;
                end
            end
        end
    endtask

    task automatic write_cfg(input int d, input int i, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_dim = d[0]; cfg_intv = 3'(i); cfg_vec = v;
        ref_mem[d][i] = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_lookup(input int i0, input int i1, input bit same_cfg,
                             input bit inj_start, input bit inj_cfg,
                             input int cd, input int ci, input logic [31:0] cv,
                             input string tag);
        int eh, er, efm, ef, cyc;
        bit busy_ok;
        @(negedge clk);
        if (same_cfg) begin
            cfg_we = 1'b1; cfg_dim = cd[0]; cfg_intv = 3'(ci); cfg_vec = cv;
            ref_mem[cd][ci] = cv;
        end
        ref_eval(i0, i1, eh, er, efm, ef);
        start = 1'b1;
        lk_intv = {3'(i1), 3'(i0)};
        cyc = 0;
        busy_ok = 1'b1;
        while (1) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
            start = 1'b0;
            cfg_we = 1'b0;
            if (cyc == 1 && inj_start) begin
                start = 1'b1;
                lk_intv = ~lk_intv;
            end
            if (cyc == 1 && inj_cfg) begin
                cfg_we = 1'b1; cfg_dim = cd[0]; cfg_intv = 3'(ci); cfg_vec = cv;
            end
            if (done) break;
            if (!busy) busy_ok = 1'b0;
            if (cyc > 64) begin
                check("R6", {tag, " lookup timeout"}, cyc, 0);
                break;
            end
        end
        check("R3",  {tag, " hit"}, int'(hit), eh);
        check("R3",  {tag, " rule_idx"}, int'(rule_idx), er);
        check("R5",  {tag, " false_match"}, int'(false_match), efm);
        check("R2 R4", {tag, " fetch_cnt"}, int'(fetch_cnt), ef);
        check("R6",  {tag, " latency"}, cyc, 2 + ((ef > 1) ? ef : 1));
        check("R6",  {tag, " busy until done"}, int'(busy_ok), 1);
        check("R6",  {tag, " busy low at done"}, int'(busy), 0);
        if (!eh) check("R11", {tag, " rule on miss"}, int'(rule_idx), 0);
    endtask

    function automatic logic [31:0] sparse_vec();
        case ($urandom % 8)
            0:       return 32'h0;
            1:       return 32'hFFFF_FFFF;
            default: return $urandom & $urandom & $urandom;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R6 watchdog expired: got 1 expected 0");
        $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        int h0, r0, f0, c0;
        void'($urandom(32'h5EED_0A1B));
        for (int d = 0; d < 2; d++)
            for (int i = 0; i < NI; i++) ref_mem[d][i] = '0;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_dim = 1'b0; cfg_intv = '0;
        cfg_vec = '0; start = 1'b0; lk_intv = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1", "busy in reset", int'(busy), 0);
        check("R1", "done in reset", int'(done), 0);
        check("R1", "hit in reset", int'(hit), 0);
        check("R1", "false_match in reset", int'(false_match), 0);
        check("R1", "rule_idx in reset", int'(rule_idx), 0);
        check("R1", "fetch_cnt in reset", int'(fetch_cnt), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "busy after reset", int'(busy), 0);

        // no candidates at all
        do_lookup(0, 0, 0, 0, 0, 0, 0, '0, "empty");

        // false match in group 0, hit at rule 9
        write_cfg(0, 2, (32'h1 << 0) | (32'h1 << 9));
        write_cfg(1, 5, (32'h1 << 1) | (32'h1 << 9));
        do_lookup(2, 5, 0, 0, 0, 0, 0, '0, "fm_then_hit");

        // priority: everything matches, rule 0 wins
        write_cfg(0, 7, 32'hFFFF_FFFF);
        write_cfg(1, 7, 32'hFFFF_FFFF);
        do_lookup(7, 7, 0, 0, 0, 0, 0, '0, "all_ones");

        // top rule reached after a false match
        write_cfg(0, 6, (32'h1 << 31) | (32'h1 << 3));
        write_cfg(1, 6, (32'h1 << 31) | (32'h1 << 2));
        do_lookup(6, 6, 0, 0, 0, 0, 0, '0, "top_rule");

        // every group a candidate, every one empty
        write_cfg(0, 4, 32'h1111_1111);
        write_cfg(1, 4, 32'h2222_2222);
        do_lookup(4, 4, 0, 0, 0, 0, 0, '0, "all_false");

        // R9: write and start in the same cycle
        write_cfg(1, 1, 32'h0000_0300);
        do_lookup(1, 1, 1, 0, 0, 0, 1, 32'h0000_0100, "R9 same_cycle");

        // R8: write during a scan is dropped
        do_lookup(2, 5, 0, 0, 1, 0, 2, 32'hFFFF_FFFF, "R8 write_busy");
        do_lookup(2, 5, 0, 0, 0, 0, 0, '0, "R8 after_drop");

        // R7: second start during a scan is ignored
        do_lookup(7, 7, 0, 1, 0, 0, 0, '0, "R7 restart");

        // R10: results hold while idle
        do_lookup(6, 6, 0, 0, 0, 0, 0, '0, "R10 base");
        h0 = int'(hit); r0 = int'(rule_idx); f0 = int'(false_match); c0 = int'(fetch_cnt);
        repeat (5) @(negedge clk);
        check("R10", "hit held", int'(hit), h0);
        check("R10", "rule held", int'(rule_idx), r0);
        check("R10", "false_match held", int'(false_match), f0);
        check("R10", "fetch_cnt held", int'(fetch_cnt), c0);
        check("R10", "done low when idle", int'(done), 0);

        // constrained random tables and lookups
        for (int round = 0; round < 20; round++) begin
            for (int d = 0; d < 2; d++)
                for (int i = 0; i < NI; i++) write_cfg(d, i, sparse_vec());
            for (int k = 0; k < 10; k++)
                do_lookup(int'($urandom % NI), int'($urandom % NI), 0, 0, 0, 0, 0, '0, "random");
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule